// File: doc/BRIEF.md
# Triple-Oversampled Serial Byte Receiver with Early Re-arm

This block turns an asynchronous serial line carrying 8-N-1 characters (eight data bits, least significant first, no parity, one stop bit) into bytes held in a small on-chip queue. A programmable divider makes a sample tick at three times the bit rate. A falling edge on the line while the receiver is enabled starts a capture of a fixed number of samples. From each group of three samples that make up one bit cell, the middle one is kept.

Each capture takes only two of the three stop-bit samples, 29 samples in all. The receiver is therefore watching for the next start edge during the last third of the stop bit. A transmitter running slightly fast, whose next start bit arrives up to a third of a bit early, is still tracked without drift. Finished bytes enter an eight-entry queue. A host sees the oldest byte on `rd_data` while `rx_avail` is high and pops it with `rd_stb`. Bytes that arrive while the queue is full are lost, and `ovf_flag` records the loss.

Top module: `osr_uart_rx`

## Requirements
- R1: A sample tick occurs once every `div_val`+1 clock cycles. One bit cell lasts three ticks.
- R2: The line passes through a two-flop synchronizer. With `rx_en` high, a capture starts on the first tick that sees the synchronized line low after the previous tick saw it high. That tick's sample is the first sample of the capture.
- R3: A capture is 29 samples long, shifted in so that the first sample ends up in bit 28. Data bit k (k=0 is the first bit sent) is taken from shift bit 24−3k, the middle sample of its cell. The byte is assembled least significant bit first.
- R4: After the 29th sample the receiver returns to edge watch at once. A start edge that arrives 2/3 of a bit into the stop bit is received correctly, including over back-to-back characters.
- R5: The stop-bit samples are not checked. A byte is queued at the end of every completed capture, even when the stop bit is low.
- R6: The queue holds 8 bytes in arrival order. `rx_avail` is high while it is not empty. `rd_data` shows the oldest byte, and `rd_stb` removes it.
- R7: A byte that completes while the queue is full is dropped and sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr` high, and setting wins over clearing in the same cycle.
- R8: While `rx_en` is low, no capture starts, and a capture in progress is abandoned without queuing a byte.
- R9: Reset (synchronous, active high) empties the queue, clears `ovf_flag` and returns the capture logic to edge watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low aborts and blocks captures |
| div_val | input | DIV_W | Tick divider; tick period is div_val+1 clocks |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_stb | input | 1 | Pops the oldest queued byte |
| ovf_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Oldest queued byte |
| rx_avail | output | 1 | Queue not empty |
| ovf_flag | output | 1 | Sticky overrun indication |

## Verification
The checker assumes that `ovf_clr` and `rd_stb` are single-cycle host strobes. It also assumes that `div_val` changes only while the line is idle, so a capture never straddles two tick rates. The bench changes the divider only between characters, with the line high. It holds each bit for exactly three tick periods, except for the deliberately shortened stop bits. It drives all strobes at the falling clock edge for one cycle at a time.

// File: rtl/osr_uart_pkg.sv
package osr_uart_pkg;
  localparam int OSR           = 3;
  localparam int DATA_W        = 8;
  localparam int STOP_SAMPLES  = 2;
  localparam int FRAME_SAMPLES = OSR * (DATA_W + 1) + STOP_SAMPLES;
  localparam int SCNT_W        = $clog2(FRAME_SAMPLES + 1);

  typedef enum logic {CAP_IDLE = 1'b0, CAP_BUSY = 1'b1} cap_state_e;

  // Shift-register position of the centre sample of data bit k
  function automatic int mid_pos(input int k);
    return FRAME_SAMPLES - 1 - (OSR * (k + 1) + OSR / 2);
  endfunction
endpackage

// File: rtl/osr_tick_gen.sv
module osr_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div_val;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/osr_rx_capture.sv
module osr_rx_capture
  import osr_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              tick,
  input  logic              line_s,
  output logic              done,
  output logic [DATA_W-1:0] byte_o,
  output logic              busy
);
  cap_state_e               state;
  logic                     prev;
  logic [SCNT_W-1:0]        cnt;
  logic [FRAME_SAMPLES-1:0] sh;
  logic [FRAME_SAMPLES-1:0] sh_nx;
  logic [DATA_W-1:0]        byte_nx;

  assign sh_nx = {sh[FRAME_SAMPLES-2:0], line_s};
  assign busy  = (state == CAP_BUSY);

  for (genvar k = 0; k < DATA_W; k++) begin : g_pick
    assign byte_nx[k] = sh_nx[mid_pos(k)];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else if (tick) prev <= line_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CAP_IDLE;
      cnt    <= '0;
      sh     <= '0;
      done   <= 1'b0;
      byte_o <= '0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        state <= CAP_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (state)
          CAP_IDLE: begin
            if (prev && !line_s) begin
              sh    <= sh_nx;
              cnt   <= SCNT_W'(1);
              state <= CAP_BUSY;
            end
          end
          default: begin
            sh <= sh_nx;
            if (cnt == SCNT_W'(FRAME_SAMPLES - 1)) begin
              done   <= 1'b1;
              byte_o <= byte_nx;
              cnt    <= '0;
              state  <= CAP_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/osr_rx_fifo.sv
module osr_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr;
  logic             do_wr, do_rd;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      if (wr_en && full) ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_uart_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              rx_line,
  input  logic              rd_stb,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_avail,
  output logic              ovf_flag
);
  logic              sync_a, sync_b;
  logic              tick;
  logic              cap_done, cap_busy;
  logic [DATA_W-1:0] cap_byte;
  logic              fifo_empty, fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= rx_line;
      sync_b <= sync_a;
    end
  end

  osr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_val(div_val), .tick(tick)
  );

  osr_rx_capture u_cap (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tick(tick), .line_s(sync_b),
    .done(cap_done), .byte_o(cap_byte), .busy(cap_busy)
  );

  osr_rx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(cap_done), .wr_data(cap_byte),
    .rd_en(rd_stb), .ovf_clr(ovf_clr), .rd_data(rd_data),
    .empty(fifo_empty), .full(fifo_full), .ovf(ovf_flag)
  );

  assign rx_avail = !fifo_empty;
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic ovf_clr,
  input logic ovf_flag,
  input logic rx_avail,
  input logic cap_done,
  input logic cap_busy,
  input logic fifo_full
);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r7_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (cap_done && fifo_full) |=> ovf_flag);

  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(cap_done && fifo_full)) |=> !ovf_flag);

  a_r6_write_shows: assert property (@(posedge clk) disable iff (rst)
    (cap_done && !fifo_full) |=> rx_avail);

  a_r6_full_avail: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> rx_avail);

  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!cap_busy && !cap_done));
endmodule

bind osr_uart_rx osr_uart_rx_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .ovf_clr(ovf_clr),
  .ovf_flag(ovf_flag), .rx_avail(rx_avail), .cap_done(cap_done),
  .cap_busy(cap_busy), .fifo_full(fifo_full)
);

// File: tb/tb_osr_uart_rx.sv
module tb_osr_uart_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic [15:0] div_val = 16'd3;
  logic        rx_line = 1'b1;
  logic        rd_stb = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        rx_avail;
  logic        ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q [$];
  bit model_ovf = 1'b0;

  always #4 clk = ~clk;

  osr_uart_rx dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .div_val(div_val),
    .rx_line(rx_line), .rd_stb(rd_stb), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .rx_avail(rx_avail), .ovf_flag(ovf_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int bit_clks();
    return 3 * (int'(div_val) + 1);
  endfunction

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  // frame: start, 8 data LSB first, stop (level and length given), then idle
  task automatic send(input logic [7:0] b, input int stop_clks, input logic stop_v, input int gap);
    hold(1'b0, bit_clks());
    for (int i = 0; i < 8; i++) hold(b[i], bit_clks());
    hold(stop_v, stop_clks);
    hold(1'b1, gap);
  endtask

  function automatic void model_push(input logic [7:0] b);
    if (exp_q.size() < 8) exp_q.push_back(b);
    else model_ovf = 1'b1;
  endfunction

  task automatic send_std(input logic [7:0] b);
    send(b, bit_clks(), 1'b1, 2 * bit_clks());
    model_push(b);
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(rx_avail == 1'b1, req, rx_avail, 1);
      check(rd_data == e, req, rd_data, e);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
    end
    check(rx_avail == 1'b0, req, rx_avail, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(rx_avail == 1'b0, "R9 avail", rx_avail, 0);
    check(ovf_flag == 1'b0, "R9 ovf", ovf_flag, 0);
    rx_en = 1'b1;
    repeat (10) @(negedge clk);

    // R2 R3 directed patterns
    send_std(8'h00); send_std(8'hFF); send_std(8'h55); send_std(8'hA5);
    drain("R3 directed");

    // R1 R3 random bytes under several tick rates
    for (int r = 0; r < 5; r++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      div_val = (sel == 0) ? 16'd1 : (sel == 1) ? 16'd2 : (sel == 2) ? 16'd3 : 16'd5;
      repeat (4) send_std(8'($urandom()));
      drain("R1 divider");
    end

    // R4 back-to-back with stop shortened to two thirds
    div_val = 16'd3;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h81 : 8'($urandom());
      send(b, 2 * bit_clks() / 3, 1'b1, 0);
      model_push(b);
    end
    hold(1'b1, 3 * bit_clks());
    drain("R4 early start");

    // R5 low stop bit still queues the byte
    send(8'h3C, bit_clks(), 1'b0, 0);
    model_push(8'h3C);
    hold(1'b1, 3 * bit_clks());
    drain("R5 stop ignored");

    // R7 overflow with nine bytes
    for (int i = 0; i < 9; i++) send_std(8'(8'h10 + i));
    check(ovf_flag == 1'b1, "R7 set", ovf_flag, 1);
    repeat (50) @(negedge clk);
    check(ovf_flag == 1'b1, "R7 sticky", ovf_flag, 1);
    drain("R6 order after overflow");
    check(ovf_flag == 1'b1, "R7 sticky after reads", ovf_flag, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    @(negedge clk);
    check(ovf_flag == 1'b0, "R7 clear", ovf_flag, 0);

    // R8 disabled receiver ignores a whole frame
    rx_en = 1'b0;
    send(8'h5A, bit_clks(), 1'b1, 2 * bit_clks());
    check(rx_avail == 1'b0, "R8 disabled", rx_avail, 0);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);

    // R8 abort mid-capture
    fork
      send(8'hC3, bit_clks(), 1'b1, 2 * bit_clks());
      begin
        repeat (50) @(negedge clk);
        rx_en = 1'b0;
      end
    join
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    check(rx_avail == 1'b0, "R8 abort", rx_avail, 0);
    send_std(8'h96);
    drain("R8 recovery");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule